// File: doc/BRIEF.md
# Text Cursor Overlay and Blink

This block applies a text cursor to the serial dot stream of a character-mode LCD controller. Each dot arrives with the refresh memory address of the character cell it belongs to and the raster line inside that character row. When the address equals the programmed cursor address, the raster line lies inside the programmed band, and the cursor is currently visible, the dot is inverted by exclusive-OR. Every dot of the matching cell carries the same refresh address, so the cursor is exactly one character pitch wide whatever the pitch is.

The cursor settings are written through four load strobes that share one byte-wide data input: the low address byte, the high address byte, the raster band byte and the mode nibble. A frame counter, stepped by a frame pulse, sets the blink rate. In graphics mode no cursor is drawn, and a display-off setting blanks the output.

Top module: `cursor_overlay`

## Requirements
- R1: After reset every setting is zero: the cursor address is 0, the band is raster 0 only, the cursor is off, the display is off, the blink counter and phase are cleared, and `pix_out` and `pix_out_valid` are 0.
- R2: With cursor mode 00 or 01 (mode nibble bits [1:0]) the output dot equals the input dot.
- R3: With cursor mode 10 the cursor shows steadily, and each dot of the matching cell inside the band is inverted.
- R4: The band byte holds the first raster minus one in bits [7:4] and the last raster minus one in bits [3:0]. A dot whose zero-based `ra` lies between these stored values, both included, is inside the band. A dot outside the band is not inverted.
- R5: Only dots whose `ma` equals the 16-bit cursor address are inverted. Dots of other cells pass unchanged.
- R6: When `char_mode` is 0 (graphics), no dot is inverted.
- R7: With cursor mode 11 the cursor blinks. The cursor shows while the blink phase is clear. The phase toggles on the frame pulse that completes a half-period: 16 pulses when nibble bit [2] is 1 and 32 pulses when it is 0. The count restarts from zero after each toggle.
- R8: When nibble bit [3] (display on) is 0, `pix_out` is 0 for every dot.
- R9: Each dot presented with `pix_valid` high yields exactly one result one clock later, with `pix_out_valid` high and dots kept in order. With no dot, `pix_out_valid` is low and `pix_out` is 0.
- R10: The low and high address bytes load independently. Writing one byte leaves the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_data | input | 8 | Shared setting byte |
| ld_addr_lo | input | 1 | Load low cursor address byte |
| ld_addr_hi | input | 1 | Load high cursor address byte |
| ld_band | input | 1 | Load raster band byte |
| ld_mode | input | 1 | Load mode nibble from cfg_data[3:0] |
| ma | input | 16 | Refresh address of the current dot's cell |
| ra | input | 4 | Zero-based raster line of the current dot |
| char_mode | input | 1 | 1 = character mode, 0 = graphics |
| frame_pulse | input | 1 | One-cycle pulse per frame |
| pix_valid | input | 1 | A dot is present |
| pix_in | input | 1 | Pattern dot |
| pix_out | output | 1 | Dot with the cursor applied |
| pix_out_valid | output | 1 | Result dot present |

## Verification
The assertions assume that reset is held low for at least one clock, that `frame_pulse` is a single-cycle pulse, and that `pix_valid` and the other inputs change only between clock edges. The bench drives every input on the falling edge, holds reset for several cycles, and issues frame pulses one at a time with an idle cycle after each. It also keeps the stored band no larger than the character height it uses and leaves the blink rate bit unchanged while it counts a half-period.

// File: rtl/cursor_ovl_pkg.sv
package cursor_ovl_pkg;
   typedef enum logic [1:0] {
      CUR_OFF_A  = 2'b00,
      CUR_OFF_B  = 2'b01,
      CUR_STEADY = 2'b10,
      CUR_BLINK  = 2'b11
   } cur_mode_e;

   typedef struct packed {
      logic      disp_on;
      logic      fast;
      cur_mode_e mode;
   } mode_cfg_t;

   localparam int MODE_BITS = $bits(mode_cfg_t);
endpackage

// File: rtl/cursor_cfg_regs.sv
module cursor_cfg_regs
   import cursor_ovl_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 16,
   parameter int RASTER_W = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [DATA_W-1:0]   cfg_data,
   input  logic                ld_addr_lo,
   input  logic                ld_addr_hi,
   input  logic                ld_band,
   input  logic                ld_mode,
   output logic [ADDR_W-1:0]   cur_addr,
   output logic [RASTER_W-1:0] row_first,
   output logic [RASTER_W-1:0] row_last,
   output mode_cfg_t           mode_cfg
);
   localparam int HI_W = ADDR_W - DATA_W;

   generate
      if (ADDR_W <= DATA_W || HI_W > DATA_W) begin : g_bad_addr
         $error("cursor_cfg_regs: ADDR_W must span two data bytes");
      end
      if (2 * RASTER_W > DATA_W) begin : g_bad_band
         $error("cursor_cfg_regs: band fields do not fit one byte");
      end
      if (MODE_BITS > DATA_W) begin : g_bad_mode
         $error("cursor_cfg_regs: mode nibble wider than data");
      end
   endgenerate

   logic [DATA_W-1:0] addr_lo_q;
   logic [HI_W-1:0]   addr_hi_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_lo_q <= '0;
         addr_hi_q <= '0;
         row_first <= '0;
         row_last  <= '0;
         mode_cfg  <= '0;
      end else begin
         if (ld_addr_lo) addr_lo_q <= cfg_data;
         if (ld_addr_hi) addr_hi_q <= cfg_data[HI_W-1:0];
         if (ld_band) begin
            row_first <= cfg_data[2*RASTER_W-1:RASTER_W];
            row_last  <= cfg_data[RASTER_W-1:0];
         end
         if (ld_mode) mode_cfg <= mode_cfg_t'(cfg_data[MODE_BITS-1:0]);
      end
   end

   assign cur_addr = {addr_hi_q, addr_lo_q};
endmodule

// File: rtl/cursor_blink.sv
module cursor_blink #(
   parameter int FAST_HALF = 16,
   parameter int SLOW_HALF = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_pulse,
   input  logic fast,
   output logic phase
);
   localparam int CNT_W = (SLOW_HALF > 2) ? $clog2(SLOW_HALF) : 1;
   localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_HALF - 1);
   localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_HALF - 1);

   generate
      if (FAST_HALF < 1 || SLOW_HALF < FAST_HALF) begin : g_bad_half
         $error("cursor_blink: need 1 <= FAST_HALF <= SLOW_HALF");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last;

   assign last = fast ? FAST_LAST : SLOW_LAST;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         phase <= 1'b0;
      end else if (frame_pulse) begin
         if (cnt_q >= last) begin
            cnt_q <= '0;
            phase <= ~phase;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/cursor_hit.sv
module cursor_hit
   import cursor_ovl_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int RASTER_W = 4
) (
   input  logic [ADDR_W-1:0]   ma,
   input  logic [RASTER_W-1:0] ra,
   input  logic                char_mode,
   input  logic [ADDR_W-1:0]   cur_addr,
   input  logic [RASTER_W-1:0] row_first,
   input  logic [RASTER_W-1:0] row_last,
   input  cur_mode_e           mode,
   input  logic                phase,
   output logic                hit
);
   logic addr_eq;
   logic in_band;
   logic shown;

   always_comb begin
      addr_eq = (ma == cur_addr);
      in_band = (ra >= row_first) && (ra <= row_last);
      unique case (mode)
         CUR_STEADY: shown = 1'b1;
         CUR_BLINK:  shown = ~phase;
         default:    shown = 1'b0;
      endcase
      hit = char_mode & addr_eq & in_band & shown;
   end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
   import cursor_ovl_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 16,
   parameter int RASTER_W  = 4,
   parameter int FAST_HALF = 16,
   parameter int SLOW_HALF = 32,
   parameter bit OUT_REG   = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [DATA_W-1:0]   cfg_data,
   input  logic                ld_addr_lo,
   input  logic                ld_addr_hi,
   input  logic                ld_band,
   input  logic                ld_mode,
   input  logic [ADDR_W-1:0]   ma,
   input  logic [RASTER_W-1:0] ra,
   input  logic                char_mode,
   input  logic                frame_pulse,
   input  logic                pix_valid,
   input  logic                pix_in,
   output logic                pix_out,
   output logic                pix_out_valid
);
   logic [ADDR_W-1:0]   cur_addr;
   logic [RASTER_W-1:0] row_first;
   logic [RASTER_W-1:0] row_last;
   mode_cfg_t           mode_cfg;
   logic                blink_phase;
   logic                cur_hit;
   logic                disp_on;
   logic                dot_next;

   cursor_cfg_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RASTER_W(RASTER_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_data(cfg_data),
      .ld_addr_lo(ld_addr_lo), .ld_addr_hi(ld_addr_hi),
      .ld_band(ld_band), .ld_mode(ld_mode),
      .cur_addr(cur_addr), .row_first(row_first),
      .row_last(row_last), .mode_cfg(mode_cfg)
   );

   cursor_blink #(
      .FAST_HALF(FAST_HALF), .SLOW_HALF(SLOW_HALF)
   ) u_blink (
      .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse),
      .fast(mode_cfg.fast), .phase(blink_phase)
   );

   cursor_hit #(
      .ADDR_W(ADDR_W), .RASTER_W(RASTER_W)
   ) u_hit (
      .ma(ma), .ra(ra), .char_mode(char_mode),
      .cur_addr(cur_addr), .row_first(row_first), .row_last(row_last),
      .mode(mode_cfg.mode), .phase(blink_phase), .hit(cur_hit)
   );

   assign disp_on  = mode_cfg.disp_on;
   assign dot_next = pix_valid & disp_on & (pix_in ^ cur_hit);

   generate
      if (OUT_REG) begin : g_out_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pix_out       <= 1'b0;
               pix_out_valid <= 1'b0;
            end else begin
               pix_out       <= dot_next;
               pix_out_valid <= pix_valid;
            end
         end
      end else begin : g_out_comb
         assign pix_out       = dot_next;
         assign pix_out_valid = pix_valid;
      end
   endgenerate
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk #(
   parameter bit OUT_REG = 1'b1
) (
   input logic clk,
   input logic rst_n,
   input logic pix_valid,
   input logic pix_in,
   input logic char_mode,
   input logic disp_on,
   input logic frame_pulse,
   input logic blink_phase,
   input logic pix_out,
   input logic pix_out_valid
);
   // R7: the phase moves only on a frame pulse
   assert_phase_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_pulse |=> $stable(blink_phase));

   // R9: no result, no dot
   assert_idle_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_out_valid |-> !pix_out);

   generate
      if (OUT_REG) begin : g_reg
         assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
            pix_valid |=> pix_out_valid);
         assert_valid_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !pix_valid |=> !pix_out_valid);
         assert_dark_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (pix_valid && !disp_on) |=> !pix_out);
         assert_graphics_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (pix_valid && disp_on && !char_mode) |=> (pix_out == $past(pix_in)));
      end else begin : g_comb
         assert_dark_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (pix_valid && !disp_on) |-> !pix_out);
         assert_graphics_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (pix_valid && disp_on && !char_mode) |-> (pix_out == pix_in));
      end
   endgenerate
endmodule

bind cursor_overlay cursor_overlay_chk #(.OUT_REG(OUT_REG)) u_chk (
   .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_in(pix_in),
   .char_mode(char_mode), .disp_on(disp_on), .frame_pulse(frame_pulse),
   .blink_phase(blink_phase), .pix_out(pix_out), .pix_out_valid(pix_out_valid)
);

// File: tb/tb_cursor_overlay.sv
module tb_cursor_overlay;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  cfg_data = '0;
   logic        ld_addr_lo = 0, ld_addr_hi = 0, ld_band = 0, ld_mode = 0;
   logic [15:0] ma = '0;
   logic [3:0]  ra = '0;
   logic        char_mode = 1'b1;
   logic        frame_pulse = 1'b0;
   logic        pix_valid = 1'b0;
   logic        pix_in = 1'b0;
   logic        pix_out, pix_out_valid;

   always #4 clk = ~clk;

   cursor_overlay dut (
      .clk(clk), .rst_n(rst_n), .cfg_data(cfg_data),
      .ld_addr_lo(ld_addr_lo), .ld_addr_hi(ld_addr_hi),
      .ld_band(ld_band), .ld_mode(ld_mode),
      .ma(ma), .ra(ra), .char_mode(char_mode), .frame_pulse(frame_pulse),
      .pix_valid(pix_valid), .pix_in(pix_in),
      .pix_out(pix_out), .pix_out_valid(pix_out_valid)
   );

   typedef struct {
      logic  e;
      string req;
      int    cyc;
   } item_t;

   item_t sb[$];
   int compared = 0;
   int mismatched = 0;
   int cyc = 0;

   // bench model of the settings, from the requirements
   logic [15:0] m_addr;
   logic [3:0]  m_first, m_last;
   logic [1:0]  m_mode;
   logic        m_fast, m_disp, m_phase;
   int          m_cnt;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(string req, logic act, logic exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %b expected %b (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   function automatic logic model_dot(logic [15:0] a, logic [3:0] r, logic cm, logic b);
      logic shown, hit;
      shown = (m_mode == 2'b10) || (m_mode == 2'b11 && !m_phase);
      hit   = cm && (a == m_addr) && (r >= m_first) && (r <= m_last) && shown;
      return m_disp & (b ^ hit);
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      pix_valid = 1'b0;
      repeat (3) @(negedge clk);
      check("R1", pix_out, 1'b0);
      check("R1", pix_out_valid, 1'b0);
      rst_n = 1'b1;
      m_addr = '0; m_first = '0; m_last = '0; m_mode = '0;
      m_fast = 0; m_disp = 0; m_phase = 0; m_cnt = 0;
   endtask

   task automatic wr_lo(logic [7:0] d);
      @(negedge clk); cfg_data = d; ld_addr_lo = 1;
      @(negedge clk); ld_addr_lo = 0;
      m_addr[7:0] = d;
   endtask

   task automatic wr_hi(logic [7:0] d);
      @(negedge clk); cfg_data = d; ld_addr_hi = 1;
      @(negedge clk); ld_addr_hi = 0;
      m_addr[15:8] = d;
   endtask

   task automatic wr_band(logic [3:0] first_m1, logic [3:0] last_m1);
      @(negedge clk); cfg_data = {first_m1, last_m1}; ld_band = 1;
      @(negedge clk); ld_band = 0;
      m_first = first_m1; m_last = last_m1;
   endtask

   task automatic wr_mode(logic disp, logic fast, logic [1:0] md);
      @(negedge clk); cfg_data = {4'h0, disp, fast, md}; ld_mode = 1;
      @(negedge clk); ld_mode = 0;
      m_disp = disp; m_fast = fast; m_mode = md;
   endtask

   task automatic frame();
      int half;
      @(negedge clk); frame_pulse = 1;
      @(negedge clk); frame_pulse = 0;
      half = m_fast ? 16 : 32;
      if (m_cnt >= half - 1) begin
         m_cnt = 0;
         m_phase = ~m_phase;
      end else begin
         m_cnt++;
      end
   endtask

   // driver: one dot, expected value pushed to the scoreboard
   task automatic send(logic [15:0] a, logic [3:0] r, logic cm, logic b, string req);
      item_t it;
      @(negedge clk);
      ma = a; ra = r; char_mode = cm; pix_in = b; pix_valid = 1;
      it.e = model_dot(a, r, cm, b);
      it.req = req;
      it.cyc = cyc;
      sb.push_back(it);
      @(negedge clk);
      pix_valid = 0;
   endtask

   task automatic send_cell(logic [15:0] a, logic [3:0] r, logic cm, logic [4:0] dots, string req);
      for (int i = 0; i < 5; i++) send(a, r, cm, dots[i], req);
   endtask

   // monitor
   always @(posedge clk) begin
      #2;
      if (rst_n && pix_out_valid) begin
         if (sb.size() == 0) begin
            compared++;
            mismatched++;
            $display("FAIL R9: actual result with no dot pending, expected none");
         end else begin
            item_t it;
            it = sb.pop_front();
            check(it.req, pix_out, it.e);
            check("R9", (cyc == it.cyc + 1), 1'b1);
         end
      end
   end

   initial begin
      #(8 * 150000);
      mismatched++;
      $display("FAIL watchdog: actual run still busy, expected finished");
      finish_run();
   end

   initial begin
      do_reset();
      // R1 / R8: reset settings leave the display dark
      send(16'h0000, 4'd0, 1, 1, "R1");
      send(16'h0000, 4'd0, 1, 1, "R8");

      // R2: modes 00 and 01 show no cursor
      wr_mode(1, 0, 2'b00);
      send_cell(16'h0000, 4'd0, 1, 5'b10110, "R2");
      wr_mode(1, 0, 2'b01);
      send_cell(16'h0000, 4'd0, 1, 5'b01101, "R2");

      // R3 / R4: steady cursor over rasters 2..6 (stored 1..5)
      wr_lo(8'h34);
      wr_hi(8'h12);
      wr_band(4'd1, 4'd5);
      wr_mode(1, 0, 2'b10);
      for (int r = 0; r < 8; r++) begin
         send_cell(16'h1234, 4'(r), 1, 5'b10011, (r >= 1 && r <= 5) ? "R3" : "R4");
      end
      // R5: neighbouring cells untouched
      send_cell(16'h1235, 4'd3, 1, 5'b11001, "R5");
      send_cell(16'h0234, 4'd3, 1, 5'b11001, "R5");

      // R10: low byte alone moves cursor to 0x1235
      wr_lo(8'h35);
      send_cell(16'h1235, 4'd2, 1, 5'b00000, "R10");
      send_cell(16'h1234, 4'd2, 1, 5'b00000, "R10");
      wr_hi(8'h56);
      send_cell(16'h5635, 4'd2, 1, 5'b11111, "R10");
      send_cell(16'h1235, 4'd2, 1, 5'b11111, "R10");

      // R6: graphics mode never shows the cursor
      send_cell(16'h5635, 4'd2, 0, 5'b01010, "R6");

      // R8: display off blanks even the cursor cell
      wr_mode(0, 0, 2'b10);
      send_cell(16'h5635, 4'd2, 1, 5'b10101, "R8");

      // R7: blink, fast rate
      do_reset();
      wr_lo(8'h40);
      wr_hi(8'h00);
      wr_band(4'd0, 4'd15);
      wr_mode(1, 1, 2'b11);
      send(16'h0040, 4'd0, 1, 0, "R7");
      repeat (15) frame();
      send(16'h0040, 4'd7, 1, 0, "R7");
      frame();
      send(16'h0040, 4'd7, 1, 0, "R7");
      repeat (15) frame();
      send(16'h0040, 4'd15, 1, 1, "R7");
      frame();
      send(16'h0040, 4'd15, 1, 1, "R7");
      // R7: blink, slow rate
      wr_mode(1, 0, 2'b11);
      repeat (31) frame();
      send(16'h0040, 4'd4, 1, 0, "R7");
      frame();
      send(16'h0040, 4'd4, 1, 0, "R7");
      repeat (32) frame();
      send(16'h0040, 4'd4, 1, 0, "R7");

      repeat (4) @(negedge clk);
      check("R9", (sb.size() == 0), 1'b1);
      check("R9", pix_out_valid, 1'b0);
      finish_run();
   end
endmodule